// File: doc/BRIEF.md
# TDM Serial Timeslot Interface

This block is the digital timeslot engine behind a telephone codec's serial port. The port carries 2048 kb/s of data in 125 µs frames of 32 channels, each channel eight bits wide. The block is clocked at 4096 kHz, which is twice the bit rate, so every bit cell lasts two clock periods. An active-low frame pulse marks the start of each frame. The block counts bit cells from that pulse and services only the first four channels. In those channels it shifts bytes out on the transmit line and captures bytes from the receive line. In every other timeslot the transmit driver is switched off.

On the parallel side the block reports each received byte with its channel number and a one-cycle strobe. It takes one transmit byte per serviced channel at the start of that channel. A mute control for each direction replaces the voice channel with the negative-zero quiet code of the selected companding law. The block also regenerates the frame pulse four channels late for a downstream device. If the frame pulse stops arriving, the block drops its sync flag and releases the line until a new frame start is seen.

Top module: `tdm_slot_if`

## Requirements
- R1: While rst_ni is low, the block is out of sync (sync_o=0), dout_oe_o=0, rx_valid_o=0 and fpd_no=1. Without a frame pulse, sync_o stays 0 after reset is released.
- R2: A frame starts at a rising clk_i edge where fp_ni is low and was high at the previous edge. From the next cycle sync_o=1, and the clocks of the frame are counted from 0 (the cycle right after that edge) to 511.
- R3: Each bit cell is two clocks long and channel bytes are sent MSB first. During frame clocks 16c+2k and 16c+2k+1, dout_o carries bit 7-k of channel c's transmit byte. The output therefore changes only at the start of a cell.
- R4: dout_oe_o is 1 exactly during frame clocks 0..63 (channels 0..3) while in sync, and 0 in all other timeslots.
- R5: din_i is sampled on the falling clk_i edge inside the second clock of each bit cell, which is the three-quarter point of the cell. Values present on din_i at other times within the cell have no effect.
- R6: A received byte for channel c (0..3) is presented on rx_data_o with rx_ch_o=c and a single-cycle rx_valid_o=1 during frame clock 16c+16. rx_valid_o is 0 in all other cycles.
- R7: The transmit byte for channel c is taken from tx_data_i[8c+7:8c] at the rising edge that begins frame clock 16c. Later changes to tx_data_i do not alter a channel that has already started.
- R8: fpd_no is low for exactly one clock, frame clock 63, so that its rising edge coincides with the start of channel 4 (32 bit cells after the frame start).
- R9: With tx_mute_i=1, channel 2 (the voice channel) carries the quiet code instead of tx_data_i. Channels 0, 1 and 3 are unaffected.
- R10: With rx_mute_i=1, the byte presented for channel 2 is the quiet code. Channels 0, 1 and 3 still carry the sampled data.
- R11: The quiet code is 8'h7F when law_i=0 (mu-law) and 8'h55 when law_i=1 (A-law).
- R12: If no frame start occurs by the edge that ends frame clock 511, sync_o falls. The block then holds dout_oe_o=0, rx_valid_o=0 and fpd_no=1 until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4096 kHz bit clock, two clocks per bit cell |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fp_ni | input | 1 | Active-low frame pulse |
| din_i | input | 1 | Serial receive stream |
| law_i | input | 1 | Companding law: 0 mu-law, 1 A-law |
| tx_mute_i | input | 1 | Send quiet code in the voice channel |
| rx_mute_i | input | 1 | Present quiet code for the received voice channel |
| tx_data_i | input | 32 | Transmit bytes, channel c in bits 8c+7:8c |
| dout_o | output | 1 | Serial transmit stream |
| dout_oe_o | output | 1 | Transmit driver enable (0 = high impedance) |
| fpd_no | output | 1 | Frame pulse delayed by four channels, active low |
| sync_o | output | 1 | Frame timing locked |
| rx_data_o | output | 8 | Received channel byte |
| rx_ch_o | output | 2 | Channel index of rx_data_o |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |

## Verification
The hardest case to reach is showing that receive data is taken only at the falling edge in the second half of each cell. A wrong sampling point still returns plausible bytes when the line is held steady for a whole cell. The bench therefore drives the complement of every bit for the whole cell except a short window around that falling edge. With this stimulus, only a design that samples at the correct edge returns the intended bytes. Loss of sync is reached by withholding the frame pulse for more than a frame. Recovery is then shown by a fresh pulse.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int CH_BITS     = 8;
  localparam int FRAME_CH    = 32;
  localparam int CLK_PER_BIT = 2;
  localparam int CLK_PER_CH  = CH_BITS * CLK_PER_BIT;

  typedef enum logic {LAW_MU = 1'b0, LAW_A = 1'b1} law_e;

  // negative-zero code of each companding law
  function automatic logic [CH_BITS-1:0] quiet_code(law_e law);
    return (law == LAW_A) ? 8'h55 : 8'h7F;
  endfunction
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter  int FRAME_CLK = 512,
  parameter  int FPD_CLK   = 63,
  localparam int CW        = $clog2(FRAME_CLK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fp_ni,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          sync_o,
  output logic          sync_nxt_o,
  output logic          fpd_no
);
  localparam logic [CW-1:0] LAST   = CW'(FRAME_CLK - 1);
  localparam logic [CW-1:0] FPD_AT = CW'(FPD_CLK);

  logic fp_d;
  logic start;

  assign start = !fp_ni && fp_d;

  always_comb begin
    if (start) begin
      cnt_nxt_o  = '0;
      sync_nxt_o = 1'b1;
    end else if (cnt_o == LAST) begin
      cnt_nxt_o  = '0;
      sync_nxt_o = 1'b0;
    end else begin
      cnt_nxt_o  = cnt_o + 1'b1;
      sync_nxt_o = sync_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_d   <= 1'b1;
      cnt_o  <= '0;
      sync_o <= 1'b0;
      fpd_no <= 1'b1;
    end else begin
      fp_d   <= fp_ni;
      cnt_o  <= cnt_nxt_o;
      sync_o <= sync_nxt_o;
      fpd_no <= !(sync_nxt_o && cnt_nxt_o == FPD_AT);
    end
  end

  p_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fp_ni && fp_d) |=> (cnt_o == '0 && sync_o));

  p_sync_drop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && cnt_o == LAST && fp_ni) |=> !sync_o);

  p_fpd_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fpd_no |=> fpd_no);
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx import tdm_pkg::*; #(
  parameter  int ACT_CH   = 4,
  parameter  int VOICE_CH = 2,
  parameter  int CW       = 9,
  localparam int CHW      = $clog2(ACT_CH),
  localparam int BW       = $clog2(CH_BITS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CW-1:0]      cnt_i,
  input  logic               sync_i,
  input  logic               din_i,
  input  logic               mute_i,
  input  logic               law_i,
  output logic [CH_BITS-1:0] rx_data_o,
  output logic [CHW-1:0]     rx_ch_o,
  output logic               rx_valid_o
);
  localparam logic [CW-1:0]  ACT_LIM   = CW'(ACT_CH * CLK_PER_CH);
  localparam logic [BW:0]    CELL_LAST = (BW + 1)'(CLK_PER_CH - 1);
  localparam logic [CHW-1:0] VOICE_IDX = CHW'(VOICE_CH);

  logic [CH_BITS-1:0] shreg;
  logic [CHW-1:0]     ch;
  logic               ch_end;

  assign ch     = cnt_i[BW+1 +: CHW];
  assign ch_end = sync_i && (cnt_i < ACT_LIM) && (cnt_i[BW:0] == CELL_LAST);

  // falling edge in the second clock of a cell = three-quarter point
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shreg <= '0;
    else if (cnt_i[0]) shreg <= {shreg[CH_BITS-2:0], din_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      rx_ch_o    <= '0;
    end else begin
      rx_valid_o <= ch_end;
      if (ch_end) begin
        rx_ch_o   <= ch;
        rx_data_o <= (mute_i && ch == VOICE_IDX) ? quiet_code(law_e'(law_i)) : shreg;
      end
    end
  end

  p_valid_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx import tdm_pkg::*; #(
  parameter  int ACT_CH   = 4,
  parameter  int VOICE_CH = 2,
  parameter  int CW       = 9,
  localparam int CHW      = $clog2(ACT_CH),
  localparam int BW       = $clog2(CH_BITS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CW-1:0]             cnt_i,
  input  logic [CW-1:0]             cnt_nxt_i,
  input  logic                      sync_i,
  input  logic                      sync_nxt_i,
  input  logic [ACT_CH*CH_BITS-1:0] tx_data_i,
  input  logic                      mute_i,
  input  logic                      law_i,
  output logic                      dout_o,
  output logic                      dout_oe_o
);
  localparam logic [CW-1:0]  ACT_LIM   = CW'(ACT_CH * CLK_PER_CH);
  localparam logic [CHW-1:0] VOICE_IDX = CHW'(VOICE_CH);
  localparam logic [BW-1:0]  MSB_IDX   = BW'(CH_BITS - 1);

  logic [CH_BITS-1:0] tx_arr [ACT_CH];
  logic [CH_BITS-1:0] tx_byte;
  logic [CHW-1:0]     ch_nxt;
  logic               load;

  for (genvar c = 0; c < ACT_CH; c++) begin : g_split
    assign tx_arr[c] = tx_data_i[c*CH_BITS +: CH_BITS];
  end

  assign ch_nxt = cnt_nxt_i[BW+1 +: CHW];
  assign load   = sync_nxt_i && (cnt_nxt_i < ACT_LIM) && (cnt_nxt_i[BW:0] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_byte <= '0;
    else if (load)
      tx_byte <= (mute_i && ch_nxt == VOICE_IDX) ? quiet_code(law_e'(law_i))
                                                 : tx_arr[ch_nxt];
  end

  assign dout_oe_o = sync_i && (cnt_i < ACT_LIM);
  assign dout_o    = dout_oe_o && tx_byte[MSB_IDX - cnt_i[BW:1]];
endmodule

// File: rtl/tdm_slot_if.sv
module tdm_slot_if import tdm_pkg::*; #(
  parameter  int ACT_CH   = 4,
  parameter  int VOICE_CH = 2,
  parameter  int DELAY_CH = 4,
  localparam int CHW      = $clog2(ACT_CH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fp_ni,
  input  logic                      din_i,
  input  logic                      law_i,
  input  logic                      tx_mute_i,
  input  logic                      rx_mute_i,
  input  logic [ACT_CH*CH_BITS-1:0] tx_data_i,
  output logic                      dout_o,
  output logic                      dout_oe_o,
  output logic                      fpd_no,
  output logic                      sync_o,
  output logic [CH_BITS-1:0]        rx_data_o,
  output logic [CHW-1:0]            rx_ch_o,
  output logic                      rx_valid_o
);
  localparam int FRAME_CLK = FRAME_CH * CLK_PER_CH;
  localparam int CW        = $clog2(FRAME_CLK);
  localparam int FPD_CLK   = DELAY_CH * CLK_PER_CH - 1;
  localparam logic [CW-1:0] ACT_END = CW'(ACT_CH * CLK_PER_CH - 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          sync_nxt;

  tdm_frame_timer #(.FRAME_CLK(FRAME_CLK), .FPD_CLK(FPD_CLK)) u_timer (
    .clk_i, .rst_ni, .fp_ni,
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .sync_o, .sync_nxt_o(sync_nxt), .fpd_no
  );

  tdm_rx #(.ACT_CH(ACT_CH), .VOICE_CH(VOICE_CH), .CW(CW)) u_rx (
    .clk_i, .rst_ni, .cnt_i(cnt), .sync_i(sync_o), .din_i,
    .mute_i(rx_mute_i), .law_i, .rx_data_o, .rx_ch_o, .rx_valid_o
  );

  tdm_tx #(.ACT_CH(ACT_CH), .VOICE_CH(VOICE_CH), .CW(CW)) u_tx (
    .clk_i, .rst_ni, .cnt_i(cnt), .cnt_nxt_i(cnt_nxt), .sync_i(sync_o),
    .sync_nxt_i(sync_nxt), .tx_data_i, .mute_i(tx_mute_i), .law_i,
    .dout_o, .dout_oe_o
  );

  p_oe_close_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_oe_o && cnt == ACT_END && fp_ni) |=> !dout_oe_o);
endmodule

// File: tb/tdm_slot_if_tb_top.sv
module tdm_slot_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fp_ni = 1'b1;
  logic        din_i = 1'b0;
  logic        law_i = 1'b0;
  logic        tx_mute_i = 1'b0;
  logic        rx_mute_i = 1'b0;
  logic [31:0] tx_data_i = '0;
  logic        dout_o, dout_oe_o, fpd_no, sync_o, rx_valid_o;
  logic [7:0]  rx_data_o;
  logic [1:0]  rx_ch_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tdm_slot_if dut_i (
    .clk_i(clk), .rst_ni, .fp_ni, .din_i, .law_i, .tx_mute_i, .rx_mute_i,
    .tx_data_i, .dout_o, .dout_oe_o, .fpd_no, .sync_o, .rx_data_o, .rx_ch_o,
    .rx_valid_o
  );

  // {law, tx_mute, rx_mute, tx bytes ch3..ch0, rx bytes ch3..ch0}
  localparam logic [66:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 32'hA53C_0FF0, 32'h1234_5678},
    {1'b1, 1'b0, 1'b0, 32'h8001_7EC3, 32'hFF00_AA55},
    {1'b0, 1'b1, 1'b0, 32'h0123_4567, 32'h89AB_CDEF},
    {1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF},
    {1'b1, 1'b0, 1'b1, 32'h6996_C33C, 32'h5AA5_0F0F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] txv, input logic [31:0] rxv,
                           input logic law, input logic txm, input logic rxm,
                           input logic chg, input logic chain);
    logic [7:0] q;
    logic [7:0] tx_exp [4];
    logic [7:0] rx_exp [4];
    q = law ? 8'h55 : 8'h7F;
    for (int c = 0; c < 4; c++) begin
      tx_exp[c] = (chg && c > 0) ? ~txv[8*c +: 8] : txv[8*c +: 8];
      if (txm && c == 2) tx_exp[c] = q;
      rx_exp[c] = (rxm && c == 2) ? q : rxv[8*c +: 8];
    end
    law_i = law; tx_mute_i = txm; rx_mute_i = rxm; tx_data_i = txv;
    if (fp_ni) begin
      @(posedge clk); #5 fp_ni = 1'b0;
    end
    @(posedge clk); #5 fp_ni = 1'b1;
    for (int i = 0; i < 512; i++) begin
      int ch = i / 16;
      int k  = (i % 16) / 2;
      logic b;
      b = (ch < 4) ? rxv[8*ch + 7 - k] : 1'b0;
      // correct bit only around the three-quarter point (R5)
      din_i = (i % 2 == 1) ? b : ~b;
      if (chg && i == 5) tx_data_i = ~txv;
      if (i == 511 && chain) fp_ni = 1'b0;
      #10;
      chk("R2 sync", {31'd0, sync_o}, 32'd1);
      chk("R4 oe", {31'd0, dout_oe_o}, {31'd0, ch < 4});
      if (ch < 4) begin
        if (chg && ch == 0)           chk("R7 dout", {31'd0, dout_o}, {31'd0, tx_exp[ch][7-k]});
        else if (txm && ch == 2)      chk("R9 R11 dout", {31'd0, dout_o}, {31'd0, tx_exp[ch][7-k]});
        else                          chk("R3 dout", {31'd0, dout_o}, {31'd0, tx_exp[ch][7-k]});
      end
      chk("R8 fpd", {31'd0, fpd_no}, {31'd0, i != 63});
      if (i == 16 || i == 32 || i == 48 || i == 64) begin
        chk("R6 valid", {31'd0, rx_valid_o}, 32'd1);
        chk("R6 ch", {30'd0, rx_ch_o}, ch - 1);
        if (rxm && ch == 3) chk("R10 R11 rx", {24'd0, rx_data_o}, {24'd0, rx_exp[ch-1]});
        else                chk("R5 rx", {24'd0, rx_data_o}, {24'd0, rx_exp[ch-1]});
      end else begin
        chk("R6 no valid", {31'd0, rx_valid_o}, 32'd0);
      end
      din_i = ~b;
      if (i < 511) begin
        @(posedge clk); #5;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #10;
    chk("R1 sync", {31'd0, sync_o}, 32'd0);
    chk("R1 oe", {31'd0, dout_oe_o}, 32'd0);
    chk("R1 valid", {31'd0, rx_valid_o}, 32'd0);
    chk("R1 fpd", {31'd0, fpd_no}, 32'd1);
    @(posedge clk); #5 rst_ni = 1'b1;
    repeat (20) @(posedge clk);
    #10;
    chk("R1 no pulse", {31'd0, sync_o}, 32'd0);
    chk("R1 oe idle", {31'd0, dout_oe_o}, 32'd0);

    for (int r = 0; r < 6; r++) begin
      logic [66:0] v;
      v = VEC[r];
      run_frame(v[63:32], v[31:0], v[66], v[65], v[64], 1'b0, 1'b1);
    end

    // R7: transmit bytes change part way through channel 0
    run_frame(32'hC3A5_5A3C, 32'h0F1E_2D3C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

    // R12: pulse withheld
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #10;
      chk("R12 sync", {31'd0, sync_o}, 32'd0);
      chk("R12 oe", {31'd0, dout_oe_o}, 32'd0);
      chk("R12 valid", {31'd0, rx_valid_o}, 32'd0);
      chk("R12 fpd", {31'd0, fpd_no}, 32'd1);
    end
    run_frame(32'h1357_9BDF, 32'h2468_ACE0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule